// File: doc/BRIEF.md
# Serial Opcode Front End with Quad Mode Switching

This block sits at the pin side of a serial memory slave. It takes in the chip select, the serial clock and four data lines as raw asynchronous inputs. It samples them in a faster system clock and picks out the first byte of each chip-select frame as that frame's opcode. For every opcode it receives, it raises a one-cycle strobe with the byte beside it, and the command decoders downstream act on that strobe.

The interface runs in one of two mutually exclusive modes, and a flag output shows which one is active. In single-line mode the opcode arrives one bit per clock on data line 0. In quad mode it arrives one nibble per clock on all four lines. The block acts on a few opcodes itself:
- 38h moves the interface to quad mode, provided the configuration input allows it.
- FFh leaves quad mode.
- 66h followed by 99h performs a software reset. The reset returns the interface to single-line mode and then ignores every command for a programmable number of system clocks.

Address, data and dummy phases are handled elsewhere.

Top module: `qspi_cmd_frontend`

## Requirements
- R1: After `rst_n` is released, `quad_mode` and `op_valid` are 0. No opcode is recognised until `cs_n` has been seen high and then low.
- R2: In single-line mode, eight rising `sclk` edges with `cs_n` low shift `sio[0]` in, most significant bit first. The block then raises `op_valid` for exactly one system clock, with that byte on `op_code`.
- R3: In quad mode, two rising `sclk` edges shift `sio[3:0]` in, high nibble first, and produce the same single strobe.
- R4: Opcode 38h received in single-line mode sets `quad_mode` when `quad_en` is 1. When `quad_en` is 0 the opcode is still strobed but `quad_mode` stays 0.
- R5: Opcode FFh received in quad mode clears `quad_mode`. Received in single-line mode, it leaves the mode unchanged.
- R6: When opcode 99h is the next complete opcode after 66h, `quad_mode` is cleared and a lockout of `RST_CYCLES` system clocks begins. During the lockout, completed opcodes produce no strobe and change no mode.
- R7: Any complete opcode other than 99h that follows 66h disarms the reset. A later 99h then has no reset effect and is strobed normally.
- R8: If `cs_n` rises before a full opcode has arrived, the partial bits are discarded and no strobe is issued. The armed or disarmed reset state is left as it was.
- R9: Only the first byte of a frame is an opcode. Further `sclk` edges in the same frame produce no strobe.
- R10: `sclk` may idle low (SPI mode 0) or high (SPI mode 3) while `cs_n` is high, and both give the same opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sio | input | 4 | Serial data lines; bit 0 carries single-line data |
| quad_en | input | 1 | Configuration bit that permits entry to quad mode |
| op_valid | output | 1 | One-cycle strobe for each accepted opcode |
| op_code | output | 8 | Opcode that goes with `op_valid` |
| quad_mode | output | 1 | 1 while the interface is in quad mode |

## Verification
A wrong mode flag shows up within the next frame. The opcode is then assembled at the wrong width, so either no strobe appears or `op_code` carries a scrambled byte. A stuck or missing arming state shows up when 99h arrives: either the lockout is missing and the next frame is strobed, or a spurious lockout swallows it. A bit counter that is not cleared between frames shows up as a strobe after a partial frame, or as an opcode shifted by several bits. These effects are visible at `op_valid` and `op_code` roughly three system clocks after the last serial edge of the affected frame.

// File: rtl/qspi_cmd_frontend.sv
module qspi_cmd_frontend #(
  parameter int RST_CYCLES = 1500,
  parameter int OPW        = 8,
  parameter int LANES      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic [LANES-1:0] sio,
  input  logic           quad_en,
  output logic           op_valid,
  output logic [OPW-1:0] op_code,
  output logic           quad_mode
);
  localparam int LCW  = $clog2(RST_CYCLES + 1);
  localparam int CNTW = $clog2(OPW);
  localparam logic [CNTW-1:0] LAST_SINGLE = CNTW'(OPW - 1);
  localparam logic [CNTW-1:0] LAST_QUAD   = CNTW'(OPW / LANES - 1);
  localparam logic [OPW-1:0] OPC_QUAD_ON  = 8'h38;
  localparam logic [OPW-1:0] OPC_QUAD_OFF = 8'hFF;
  localparam logic [OPW-1:0] OPC_ARM      = 8'h66;
  localparam logic [OPW-1:0] OPC_RESET    = 8'h99;

  logic cs_m, cs_s, cs_d;
  logic ck_m, ck_s, ck_d;
  logic [LANES-1:0] io_m, io_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {cs_m, cs_s, cs_d} <= '0;
      {ck_m, ck_s, ck_d} <= '0;
      io_m <= '0;
      io_s <= '0;
    end else begin
      cs_m <= cs_n;  cs_s <= cs_m;  cs_d <= cs_s;
      ck_m <= sclk;  ck_s <= ck_m;  ck_d <= ck_s;
      io_m <= sio;   io_s <= io_m;
    end

  wire cs_fall = cs_d & ~cs_s;
  wire ck_rise = ck_s & ~ck_d;

  logic in_frame, got_byte;
  logic [CNTW-1:0] bit_cnt;
  logic [OPW-1:0]  shreg;
  logic [LCW-1:0]  lock_cnt;
  logic            armed;
  logic            locked;

  wire shift_en = in_frame & ~cs_s & ~got_byte & ck_rise;
  wire [OPW-1:0] nxt = quad_mode ? {shreg[OPW-LANES-1:0], io_s} : {shreg[OPW-2:0], io_s[0]};
  wire is_last  = (bit_cnt == (quad_mode ? LAST_QUAD : LAST_SINGLE));
  wire byte_done = shift_en & is_last;
  assign locked = (lock_cnt != '0);
  wire accept = byte_done & ~locked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0;
      got_byte <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (cs_s) begin
      in_frame <= 1'b0;
      got_byte <= 1'b0;
      bit_cnt  <= '0;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      got_byte <= 1'b0;
      bit_cnt  <= '0;
    end else if (shift_en) begin
      shreg   <= nxt;
      bit_cnt <= bit_cnt + 1'b1;
      if (is_last) got_byte <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_valid  <= 1'b0;
      op_code   <= '0;
      quad_mode <= 1'b0;
      armed     <= 1'b0;
      lock_cnt  <= '0;
    end else begin
      op_valid <= accept;
      if (accept) begin
        op_code <= nxt;
        armed   <= (nxt == OPC_ARM);
        unique case (nxt)
          OPC_QUAD_ON:  if (quad_en) quad_mode <= 1'b1;
          OPC_QUAD_OFF: quad_mode <= 1'b0;
          OPC_RESET:    if (armed) quad_mode <= 1'b0;
          default: ;
        endcase
      end
      if (accept && nxt == OPC_RESET && armed)
        lock_cnt <= LCW'(RST_CYCLES);
      else if (locked)
        lock_cnt <= lock_cnt - 1'b1;
    end
endmodule

// File: rtl/qspi_cmd_frontend_chk.sv
module qspi_cmd_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [7:0] op_code,
  input logic       quad_mode,
  input logic       quad_en,
  input logic       locked
);
  // R2 / R9: one strobe lasts exactly one system clock
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  assert_quad_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quad_mode) |-> op_valid && op_code == 8'h38 && $past(quad_en));

  assert_quad_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quad_mode) |-> op_valid && (op_code == 8'hFF || op_code == 8'h99));

  assert_lockout_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> op_valid && op_code == 8'h99 && !quad_mode);

  assert_lockout_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !$past(locked));
endmodule

bind qspi_cmd_frontend qspi_cmd_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .quad_mode(quad_mode), .quad_en(quad_en), .locked(locked)
);

// File: tb/sim_qspi_cmd_frontend.sv
module sim_qspi_cmd_frontend;
  localparam int RSTC = 300;
  logic clk = 0, rst_n = 0, cs_n = 0, sclk = 0, quad_en = 0;
  logic [3:0] sio = 0;
  logic op_valid, quad_mode;
  logic [7:0] op_code;
  int tests = 0, fails = 0, nstrobe = 0;
  logic [7:0] last_code = 0;

  always #10 clk = ~clk;

  qspi_cmd_frontend #(.RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio(sio),
    .quad_en(quad_en), .op_valid(op_valid), .op_code(op_code), .quad_mode(quad_mode));

  always @(negedge clk) if (op_valid) begin
    nstrobe++;
    last_code = op_code;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic frame(input logic [15:0] d, input bit q, input bit cpol, input int nclk);
    sclk = cpol; cs_n = 1; wt(6);
    cs_n = 0; wt(4);
    for (int i = 0; i < nclk; i++) begin
      sclk = 0;
      sio = q ? d[15-4*i -: 4] : {3'b000, d[15-i]};
      wt(4);
      sclk = 1; wt(4);
    end
    sclk = cpol; wt(4);
    cs_n = 1; wt(8);
  endtask

  // {quad_en, cpol, opcode, strobe expected, quad_mode after}
  localparam logic [11:0] VEC [13] = '{
    {2'b00, 8'h9F, 2'b10}, {2'b01, 8'h38, 2'b10}, {2'b10, 8'h38, 2'b11},
    {2'b11, 8'h05, 2'b11}, {2'b10, 8'h38, 2'b11}, {2'b10, 8'hFF, 2'b10},
    {2'b00, 8'hFF, 2'b10}, {2'b10, 8'h66, 2'b10}, {2'b10, 8'h05, 2'b10},
    {2'b10, 8'h99, 2'b10}, {2'b10, 8'h38, 2'b11}, {2'b10, 8'h66, 2'b11},
    {2'b10, 8'h99, 2'b10}};

  function automatic string vreq(input int i);
    case (i)
      0: return "R2";  1: return "R4_R10"; 2: return "R4"; 3: return "R3_R10";
      4: return "R4";  5: return "R5"; 6: return "R5"; 7: return "R2";
      8: return "R7";  9: return "R7"; 10: return "R4"; 11: return "R3";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit q;
    int n0;
    wt(3); rst_n = 1; wt(3);
    chk(quad_mode == 0 && op_valid == 0, "R1 reset state", {op_valid, quad_mode}, 0);
    n0 = nstrobe;
    for (int i = 0; i < 8; i++) begin
      sclk = 0; sio = {3'b0, i[0]}; wt(4); sclk = 1; wt(4);
    end
    sclk = 0; wt(8);
    chk(nstrobe == n0, "R1 no opcode before cs_n high", nstrobe - n0, 0);

    q = 0;
    for (int i = 0; i < 13; i++) begin
      n0 = nstrobe;
      quad_en = VEC[i][11];
      frame({VEC[i][9:2], 8'h00}, q, VEC[i][10], q ? 2 : 8);
      chk(nstrobe - n0 == int'(VEC[i][1]), vreq(i), nstrobe - n0, VEC[i][1]);
      chk(last_code == VEC[i][9:2], vreq(i), last_code, VEC[i][9:2]);
      chk(quad_mode == VEC[i][0], vreq(i), quad_mode, VEC[i][0]);
      q = VEC[i][0];
    end

    // R6: lockout swallows commands, including a mode change
    n0 = nstrobe;
    frame(16'h9F00, 0, 0, 8);
    frame(16'h3800, 0, 0, 8);
    chk(nstrobe == n0, "R6 strobe during lockout", nstrobe - n0, 0);
    chk(quad_mode == 0, "R6 mode during lockout", quad_mode, 0);
    wt(RSTC);
    n0 = nstrobe;
    frame(16'h9F00, 0, 0, 8);
    chk(nstrobe - n0 == 1 && last_code == 8'h9F, "R6 after lockout", last_code, 8'h9F);

    // R8: partial frame discarded
    n0 = nstrobe;
    frame(16'hA500, 0, 0, 5);
    chk(nstrobe == n0, "R8 partial no strobe", nstrobe - n0, 0);
    frame(16'h0500, 0, 1, 8);
    chk(nstrobe - n0 == 1 && last_code == 8'h05, "R8 next frame clean", last_code, 8'h05);

    // R8: partial frame between 66h and 99h keeps the arming
    frame(16'h6600, 0, 0, 8);
    frame(16'h1200, 0, 0, 3);
    n0 = nstrobe;
    frame(16'h9900, 0, 0, 8);
    frame(16'h0500, 0, 0, 8);
    chk(nstrobe - n0 == 1, "R8 arming survives partial", nstrobe - n0, 1);
    wt(RSTC);

    // R9: only the first byte of a frame
    n0 = nstrobe;
    frame(16'hC3FF, 0, 0, 16);
    chk(nstrobe - n0 == 1 && last_code == 8'hC3, "R9 one opcode per frame", last_code, 8'hC3);
    quad_en = 1;
    frame(16'h3800, 0, 0, 8);
    n0 = nstrobe;
    frame(16'h5AFF, 1, 0, 4);
    chk(nstrobe - n0 == 1 && last_code == 8'h5A, "R9 R3 quad extra nibbles", last_code, 8'h5A);
    chk(quad_mode == 1, "R9 quad kept", quad_mode, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule